// File: doc/BRIEF.md
# Back-EMF Stall Detector

This block watches the back-EMF of a running stepper motor and decides when the rotor has stalled. Once per coil zero crossing, it waits a programmable settling time and then takes one back-EMF code from an external converter. While the motion is in its constant-velocity phase, it compares that code with two limits. The first is an absolute floor. The second is a symmetric band around a running average of earlier good samples. Any violation sets a sticky cause flag and raises a one-cycle request to stop the motor at once.

Detection is armed only in the cruise phase, and only after a programmable number of full steps have passed since cruise began. This keeps the acceleration ramp and its settling from causing false trips. The check can also be withheld while the current regulator runs at full duty, since the back-EMF reading is not trustworthy then. Setting both threshold indices to zero turns detection off completely. The cause flags stay set until a status read clears them.

Top module: `bemf_stall_det`

## Requirements
- R1: After reset, `stall_abs`, `stall_lo`, `stall_hi`, `stall` and `halt_req` are all 0.
- R2: A `zc_pulse` seen at a clock edge T (re)starts the sample delay. The sample is the `adc_code` present at edge T+D, where D = floor(87*(`delay_sel`+2)/2) * TICKS_PER_MS. With one tick per ms this gives 87, 130, 174, 217, 261, 304, 348 and 391 cycles for codes 0 to 7. A code present only at edge T+D-1 is not used.
- R3: For a nonzero `abs_idx`, a checked sample strictly below `abs_idx` * ABS_STEP sets `stall_abs`. ABS_STEP = 2*DEL_STEP, which is 8 codes by default.
- R4: For a nonzero `del_idx`, with a valid average A and delta = `del_idx` * DEL_STEP (4 codes by default), a checked sample s sets `stall_lo` when s + delta < A and sets `stall_hi` when s > A + delta. Equality sets neither.
- R5: An index of 0 disables its own comparison. When both indices are 0, no flag is ever set.
- R6: A sample is checked only when `phase` is cruise and the full steps counted since cruise began have reached `arm_steps` (0 to 7). The count saturates at 7. `phase` encodes 2'b00 idle, 2'b01 accelerate, 2'b10 cruise, 2'b11 decelerate. Leaving cruise clears the count.
- R7: The running average uses the accumulator acc, with average A = floor(acc/8). The first sample in cruise that causes no violation seeds acc = 8*s. Each later non-violating sample in cruise sets acc = acc - floor(acc/8) + s. Violating samples leave acc unchanged. Leaving cruise invalidates the average, and the band checks are skipped while it is invalid.
- R8: `stall` is the OR of the three cause flags. The flags are sticky until `status_read` is high at a clock edge, which clears them. A new violation at that same edge still sets its flag.
- R9: `halt_req` is high for exactly the one cycle after the edge at which a violation was sampled.
- R10: While `duty_full` is 1 and `duty_full_en` is 0, samples are not checked. With `duty_full_en` set to 1, they are checked normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_pulse | input | 1 | Coil current zero crossing, one cycle |
| adc_code | input | SW | Back-EMF sample code |
| phase | input | 2 | Motion phase: 00 idle, 01 accel, 10 cruise, 11 decel |
| fs_pulse | input | 1 | One full step done, one cycle |
| abs_idx | input | 4 | Absolute threshold index, 0 = off |
| del_idx | input | 4 | Delta band index, 0 = off |
| arm_steps | input | 3 | Full steps into cruise before arming |
| delay_sel | input | 3 | Sample delay code after zero crossing |
| duty_full | input | 1 | Current regulator at 100% duty |
| duty_full_en | input | 1 | Allow checks during 100% duty |
| status_read | input | 1 | Clears the sticky flags |
| stall_abs | output | 1 | Sample fell under the absolute floor |
| stall_lo | output | 1 | Sample fell under the band |
| stall_hi | output | 1 | Sample rose over the band |
| stall | output | 1 | OR of the cause flags |
| halt_req | output | 1 | One-cycle immediate stop request |

## Verification
The ports show a wrong delay count as a flag that tracks the code one edge too early rather than the code at the exact sampling edge. Each delay code is therefore probed with a code that is present at only one edge. A corrupted average or arming count does not show up until the next sample, which comes at least 87 cycles later. At that sample, a band or arming violation appears at the boundary value, one code either side of the limit. Each index is swept over its full range at these edges, so an off-by-one comparison or a wrong step size gives a wrong flag within one sample period.

// File: rtl/bemf_stall_det.sv
module bemf_stall_det #(
  parameter int SW           = 8,
  parameter int DEL_STEP     = 4,
  parameter int TICKS_PER_MS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_pulse,
  input  logic [SW-1:0] adc_code,
  input  logic [1:0]    phase,
  input  logic          fs_pulse,
  input  logic [3:0]    abs_idx,
  input  logic [3:0]    del_idx,
  input  logic [2:0]    arm_steps,
  input  logic [2:0]    delay_sel,
  input  logic          duty_full,
  input  logic          duty_full_en,
  input  logic          status_read,
  output logic          stall_abs,
  output logic          stall_lo,
  output logic          stall_hi,
  output logic          stall,
  output logic          halt_req
);
  localparam int ABS_STEP = 2 * DEL_STEP;
  localparam int MAX_TICKS = 391 * TICKS_PER_MS;
  localparam int TW = $clog2(MAX_TICKS + 1);
  localparam int AW = SW + 3;
  localparam int CW = 32;
  localparam logic [1:0] PH_CRUISE = 2'b10;

  function automatic logic [TW-1:0] delay_ticks(input logic [2:0] s);
    return TW'((87 * (int'(s) + 2) / 2) * TICKS_PER_MS);
  endfunction

  logic [TW-1:0] timer;
  logic [2:0]    steps;
  logic [AW-1:0] acc;
  logic          avg_ok;

  wire cruise  = (phase == PH_CRUISE);
  wire take    = (timer == TW'(1));
  wire armed   = cruise && (steps >= arm_steps);
  wire det_en  = (abs_idx != 4'd0) || (del_idx != 4'd0);
  wire duty_ok = !duty_full || duty_full_en;
  wire check   = take && armed && det_en && duty_ok;

  wire [CW-1:0] smp     = CW'(adc_code);
  wire [CW-1:0] avg     = CW'(acc[AW-1:3]);
  wire [CW-1:0] abs_lim = CW'(abs_idx) * CW'(ABS_STEP);
  wire [CW-1:0] dlt     = CW'(del_idx) * CW'(DEL_STEP);

  wire hit_abs = check && (abs_idx != 4'd0) && (smp < abs_lim);
  wire hit_lo  = check && avg_ok && (del_idx != 4'd0) && (smp + dlt < avg);
  wire hit_hi  = check && avg_ok && (del_idx != 4'd0) && (smp > avg + dlt);
  wire hit     = hit_abs | hit_lo | hit_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) timer <= '0;
    else if (zc_pulse) timer <= delay_ticks(delay_sel);
    else if (timer != '0) timer <= timer - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) steps <= '0;
    else if (!cruise) steps <= '0;
    else if (fs_pulse && steps != 3'd7) steps <= steps + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      avg_ok <= 1'b0;
    end else if (!cruise) begin
      avg_ok <= 1'b0;
    end else if (take && !hit) begin
      avg_ok <= 1'b1;
      if (!avg_ok) acc <= {adc_code, 3'b000};
      else         acc <= acc - (acc >> 3) + AW'(adc_code);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_abs <= 1'b0;
      stall_lo  <= 1'b0;
      stall_hi  <= 1'b0;
      halt_req  <= 1'b0;
    end else begin
      stall_abs <= (stall_abs & !status_read) | hit_abs;
      stall_lo  <= (stall_lo  & !status_read) | hit_lo;
      stall_hi  <= (stall_hi  & !status_read) | hit_hi;
      halt_req  <= hit;
    end
  end

  assign stall = stall_abs | stall_lo | stall_hi;

  // R2
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= TW'(MAX_TICKS));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !status_read) |=> $stable({stall_abs, stall_lo, stall_hi}));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_read && !take) |=> !stall);

  // R9
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> stall);

  // R6
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !armed) |=> !halt_req);

  // R5
  abs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abs_idx == 4'd0 && !status_read) |=> $stable(stall_abs));

  // R10
  duty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_full && !duty_full_en) |=> !halt_req);
endmodule

// File: tb/bemf_stall_det_tb.sv
module bemf_stall_det_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_pulse = 1'b0, fs_pulse = 1'b0, duty_full = 1'b0, duty_full_en = 1'b0, status_read = 1'b0;
  logic [7:0] adc_code = 8'hFF;
  logic [1:0] phase = 2'b00;
  logic [3:0] abs_idx = 4'd0, del_idx = 4'd0;
  logic [2:0] arm_steps = 3'd0, delay_sel = 3'd0;
  logic stall_abs, stall_lo, stall_hi, stall, halt_req;

  int n_chk = 0, n_bad = 0;
  int m_acc = 0, m_steps = 0;
  bit m_valid = 0, m_cruise = 0;
  logic [2:0] e_flags = 3'b000;

  always #(CLK_PERIOD/2) clk = ~clk;

  bemf_stall_det u_dut (
    .clk(clk), .rst_n(rst_n), .zc_pulse(zc_pulse), .adc_code(adc_code), .phase(phase),
    .fs_pulse(fs_pulse), .abs_idx(abs_idx), .del_idx(del_idx), .arm_steps(arm_steps),
    .delay_sel(delay_sel), .duty_full(duty_full), .duty_full_en(duty_full_en),
    .status_read(status_read), .stall_abs(stall_abs), .stall_lo(stall_lo),
    .stall_hi(stall_hi), .stall(stall), .halt_req(halt_req));

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual {halt,stall,hi,lo,abs}=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic int dly(int s);
    return 87 * (s + 2) / 2;
  endfunction

  task automatic enter_cruise();
    phase = 2'b01; @(negedge clk);
    phase = 2'b10; m_cruise = 1; m_valid = 0; m_steps = 0;
  endtask

  task automatic full_step();
    fs_pulse = 1'b1; @(negedge clk); fs_pulse = 1'b0; @(negedge clk);
    if (m_steps < 7) m_steps++;
  endtask

  task automatic clear_flags(string tag);
    status_read = 1'b1; @(negedge clk); status_read = 1'b0;
    e_flags = 3'b000;
    check(tag, {halt_req, stall, stall_hi, stall_lo, stall_abs}, 5'b00000);
  endtask

  // off = 0: value at the sampling edge; off = -1: one edge early
  task automatic do_sample(int val, int off, string tag);
    int d, s, avg;
    bit chk, ea, el, eh;
    d = dly(int'(delay_sel));
    s = (off == 0) ? val : 255;
    avg = m_acc / 8;
    chk = m_cruise && (m_steps >= int'(arm_steps)) && (abs_idx != 0 || del_idx != 0)
          && (!duty_full || duty_full_en);
    ea = chk && abs_idx != 0 && s < int'(abs_idx) * 8;
    el = chk && m_valid && del_idx != 0 && s + int'(del_idx) * 4 < avg;
    eh = chk && m_valid && del_idx != 0 && s > avg + int'(del_idx) * 4;
    zc_pulse = 1'b1; @(negedge clk); zc_pulse = 1'b0;
    repeat (d - 1 + off) @(negedge clk);
    adc_code = 8'(val); @(negedge clk); adc_code = 8'hFF;
    if (off == -1) @(negedge clk);
    e_flags = e_flags | {eh, el, ea};
    check(tag, {halt_req, stall, stall_hi, stall_lo, stall_abs},
          {ea | el | eh, |e_flags, e_flags});
    if (m_cruise && !(ea | el | eh)) begin
      if (!m_valid) m_acc = 8 * s; else m_acc = m_acc - m_acc / 8 + s;
      m_valid = 1;
    end
    @(negedge clk);
    check({tag, " R9 pulse"}, {3'b000, halt_req, 1'b0}, 5'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {halt_req, stall, stall_hi, stall_lo, stall_abs}, 5'b00000);
    rst_n = 1'b1; @(negedge clk);

    // R2 sweep of delay codes, value one edge early vs on the edge
    abs_idx = 4'd15;
    enter_cruise();
    for (int c = 0; c < 8; c++) begin
      delay_sel = 3'(c);
      do_sample(0, -1, "R2 early");
      do_sample(0, 0, "R2 exact");
      clear_flags("R8 clear");
    end
    delay_sel = 3'd0;

    // R3 absolute sweep at the boundary
    for (int a = 1; a < 16; a++) begin
      abs_idx = 4'(a);
      do_sample(a * 8, 0, "R3 at limit");
      do_sample(a * 8 - 1, 0, "R3 below");
      clear_flags("R8 clear");
    end

    // R4 / R7 band sweep
    abs_idx = 4'd0;
    for (int d = 1; d < 16; d++) begin
      del_idx = 4'(d);
      enter_cruise();
      do_sample(100, 0, "R7 seed");
      do_sample(m_acc / 8 - 4 * d, 0, "R4 lo edge");
      do_sample(m_acc / 8 - 4 * d - 1, 0, "R4 lo hit");
      do_sample(m_acc / 8 + 4 * d, 0, "R4 hi edge");
      do_sample(m_acc / 8 + 4 * d + 1, 0, "R4 hi hit");
      clear_flags("R8 clear");
    end

    // R7 average drift then band relative to new average
    del_idx = 4'd2;
    enter_cruise();
    do_sample(60, 0, "R7 seed");
    for (int i = 0; i < 6; i++) do_sample(140, 0, "R7 track");
    do_sample(m_acc / 8 + 9, 0, "R7 band follows");
    clear_flags("R8 clear");

    // R5 both off
    del_idx = 4'd0; abs_idx = 4'd0;
    do_sample(0, 0, "R5 all off");
    // R5 abs off, band on: low code only hits band
    del_idx = 4'd1;
    enter_cruise();
    do_sample(50, 0, "R5 seed");
    do_sample(0, 0, "R5 abs off");
    clear_flags("R8 clear");
    del_idx = 4'd0;

    // R6 arming after full steps
    abs_idx = 4'd1;
    for (int k = 0; k < 8; k++) begin
      arm_steps = 3'(k);
      enter_cruise();
      for (int p = 0; p < k - 1; p++) full_step();
      if (k > 0) do_sample(0, 0, "R6 not armed");
      if (k > 0) full_step();
      do_sample(0, 0, "R6 armed");
      clear_flags("R8 clear");
    end
    arm_steps = 3'd0;
    // R6 non-cruise phases never checked
    phase = 2'b11; m_cruise = 0; @(negedge clk);
    do_sample(0, 0, "R6 decel");
    phase = 2'b01;
    do_sample(0, 0, "R6 accel");

    // R10 full duty gating
    enter_cruise();
    duty_full = 1'b1; duty_full_en = 1'b0;
    do_sample(0, 0, "R10 blocked");
    duty_full_en = 1'b1;
    do_sample(0, 0, "R10 allowed");
    // R8 sticky across a clean sample
    duty_full = 1'b0;
    do_sample(200, 0, "R8 sticky");
    clear_flags("R8 clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule